// File: doc/BRIEF.md
# Data Bus Grant Scheduler Without Busy Sensing

This block is the system-side scheduler for a shared data bus whose masters keep their data-bus-busy outputs to themselves, so bus ownership is decided by the grants alone. Each completed address phase posts a data tenure request here: the requesting master's number and a flag that says whether the transfer is a burst or a single beat. Requests wait in a small in-order queue. Only one tenure runs at a time.

The scheduler never sees a busy line. It follows every tenure by counting transfer acknowledges against the expected beat count, so it knows when the tenure ends. A grant is a single-cycle pulse to one master, raised in the cycle just before that master may start driving data. When the next owner is a different master, its grant coincides with the final acknowledge of the running tenure, so the bus is handed over with no idle cycle. A master that has just finished needs one cycle to drop its own busy output, so it is never granted again until that cycle has passed.

Top module: `databus_sched`

## Requirements
- R1: While `rst` is high no grant line is asserted, and a request presented during reset is discarded. After reset the queue is empty and no grant is raised until a new request arrives.
- R2: At most one bit of `grant_o` is high in any cycle. Bit k belongs to master number k. Each grant lasts one cycle and then removes the request from the queue.
- R3: With no tenure running and an empty queue, a request captured at a clock edge produces its grant in the cycle that follows that edge.
- R4: Grants are issued in the order in which their requests were accepted.
- R5: A tenure starts in the cycle after its grant. It ends on its 4th acknowledge when the request's burst flag is 1, and on its 1st acknowledge when the flag is 0. Cycles with `ta_i` low add wait states and do not advance the count.
- R6: When the queue head belongs to a master other than the current owner, the head's grant is asserted in the same cycle as the current tenure's final acknowledge.
- R7: A master whose tenure ends with the acknowledge in cycle t is not granted in cycle t or in cycle t+1. Its earliest next grant is in cycle t+2.
- R8: An acknowledge that arrives while no tenure is running changes nothing. No grant appears, and the next tenure still needs its full beat count.
- R9: The queue holds six requests. A request that arrives while six are already waiting is dropped and never granted.
- R10: No grant is issued in a cycle in which a running tenure is not taking its final acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Posts one data tenure request this cycle |
| req_id_i | input | 2 | Master number of the request |
| req_burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| ta_i | input | 1 | Transfer acknowledge for the current beat |
| grant_o | output | 4 | One-cycle data bus grant, one bit per master |

## Verification
A wrong beat counter shows at the ports on the tenure's last acknowledge: the next grant comes early, before the final beat, or late, one or more cycles after it. A corrupted queue shows as a grant to the wrong master, in the wrong order, or to a request that should have been dropped, and it shows at the next grant. A lost turnaround flag shows as a grant to the same master in the last-acknowledge cycle or the cycle after it, so the directed tests look at every cycle near each tenure boundary and expect exact grant vectors.

// File: rtl/databus_sched_pkg.sv
package databus_sched_pkg;

  // Beat total of one tenure: burst_len beats for a burst, one otherwise.
  function automatic int unsigned beat_total(input logic burst, input int unsigned burst_len);
    return burst ? burst_len : 1;
  endfunction

  // Wrap a queue pointer inside a depth that need not be a power of two.
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/databus_sched_queue.sv
module databus_sched_queue #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned W     = 3,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  import databus_sched_pkg::*;

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        slot[wr_ptr] <= push_data;
        wr_ptr       <= PW'(ptr_next(int'(wr_ptr), DEPTH));
      end
      if (do_pop) rd_ptr <= PW'(ptr_next(int'(rd_ptr), DEPTH));
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/databus_sched_tenure.sv
module databus_sched_tenure #(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned ID_W      = 2,
  localparam int unsigned BW       = $clog2(BURST_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [ID_W-1:0] start_id,
  input  logic            start_burst,
  input  logic            ta_i,
  output logic            active,
  output logic            tenure_end,
  output logic [ID_W-1:0] cur_id,
  output logic            turn_v,
  output logic [ID_W-1:0] turn_id
);
  import databus_sched_pkg::*;

  logic [BW-1:0] remaining;
  logic          final_beat;

  assign final_beat = active && (remaining == BW'(1));
  assign tenure_end = final_beat && ta_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      remaining <= '0;
      cur_id    <= '0;
      turn_v    <= 1'b0;
      turn_id   <= '0;
    end else begin
      turn_v <= tenure_end;
      if (tenure_end) turn_id <= cur_id;
      if (start) begin
        active    <= 1'b1;
        remaining <= BW'(beat_total(start_burst, BURST_LEN));
        cur_id    <= start_id;
      end else if (tenure_end) begin
        active <= 1'b0;
      end else if (active && ta_i) begin
        remaining <= remaining - 1'b1;
      end
    end
  end

endmodule

// File: rtl/databus_sched.sv
module databus_sched #(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned DEPTH       = 6,
  parameter int unsigned BURST_LEN   = 4,
  localparam int unsigned ID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid_i,
  input  logic [ID_W-1:0]        req_id_i,
  input  logic                   req_burst_i,
  input  logic                   ta_i,
  output logic [NUM_MASTERS-1:0] grant_o
);

  logic [ID_W:0]   head;
  logic [ID_W-1:0] head_id;
  logic            head_burst;
  logic            q_empty, q_full;
  logic [CW-1:0]   fifo_cnt;

  logic            ten_active, tenure_end, turn_v;
  logic [ID_W-1:0] cur_id, turn_id;

  logic            bus_free, owner_block, turn_block, grant_fire;

  databus_sched_queue #(.DEPTH(DEPTH), .W(ID_W + 1)) queue_i (
    .clk       (clk),
    .rst       (rst),
    .push      (req_valid_i),
    .push_data ({req_id_i, req_burst_i}),
    .pop       (grant_fire),
    .head      (head),
    .empty     (q_empty),
    .full      (q_full),
    .count     (fifo_cnt)
  );

  assign head_id    = head[ID_W:1];
  assign head_burst = head[0];

  databus_sched_tenure #(.BURST_LEN(BURST_LEN), .ID_W(ID_W)) tenure_i (
    .clk         (clk),
    .rst         (rst),
    .start       (grant_fire),
    .start_id    (head_id),
    .start_burst (head_burst),
    .ta_i        (ta_i),
    .active      (ten_active),
    .tenure_end  (tenure_end),
    .cur_id      (cur_id),
    .turn_v      (turn_v),
    .turn_id     (turn_id)
  );

  // Bus becomes free for the next owner on the final acknowledge.
  assign bus_free    = !ten_active || tenure_end;
  // Same master still owns the bus, or is dropping its busy output.
  assign owner_block = ten_active && (head_id == cur_id);
  assign turn_block  = turn_v && (head_id == turn_id);
  assign grant_fire  = !rst && !q_empty && bus_free && !owner_block && !turn_block;

  for (genvar k = 0; k < NUM_MASTERS; k++) begin : g_grant
    assign grant_o[k] = grant_fire && (head_id == ID_W'(k));
  end

endmodule

// File: rtl/databus_sched_chk.sv
module databus_sched_chk #(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned DEPTH       = 6,
  parameter int unsigned ID_W        = 2,
  parameter int unsigned CW          = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_MASTERS-1:0] grant_o,
  input logic                   ten_active,
  input logic                   tenure_end,
  input logic [ID_W-1:0]        cur_id,
  input logic [CW-1:0]          fifo_cnt
);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (grant_o == '0));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (fifo_cnt == '0));

  // R9
  queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  // R10
  mid_tenure_chk: assert property (@(posedge clk) disable iff (rst)
    (ten_active && !tenure_end) |-> (grant_o == '0));

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    tenure_end |=> !grant_o[$past(cur_id)]);

  // R5
  grant_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0) |=> ten_active);

  // R2
  grant_pops_chk: assert property (@(posedge clk) disable iff (rst)
    ((grant_o != '0) && $past(!rst)) |=> (fifo_cnt <= $past(fifo_cnt)));

endmodule

bind databus_sched databus_sched_chk #(
  .NUM_MASTERS (NUM_MASTERS),
  .DEPTH       (DEPTH),
  .ID_W        (ID_W),
  .CW          (CW)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .grant_o    (grant_o),
  .ten_active (ten_active),
  .tenure_end (tenure_end),
  .cur_id     (cur_id),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/databus_sched_tb.sv
module databus_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_id_i = '0;
  logic       req_burst_i = 1'b0;
  logic       ta_i = 1'b0;
  logic [3:0] grant_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  databus_sched dut_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_id_i    (req_id_i),
    .req_burst_i (req_burst_i),
    .ta_i        (ta_i),
    .grant_o     (grant_o)
  );

  // One cycle: drive on the falling edge, check the grant just after.
  task automatic step(input logic ta, input logic rv, input logic [1:0] rid,
                      input logic rb, input logic [3:0] exp, input string tag);
    @(negedge clk);
    ta_i        = ta;
    req_valid_i = rv;
    req_id_i    = rid;
    req_burst_i = rb;
    #1;
    checks++;
    if (grant_o !== exp) begin
      failures++;
      $display("FAIL %s grant actual=%b expected=%b", tag, grant_o, exp);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 1'b0, 4'b0000, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b0, 1'b1, 2'd1, 1'b0, 4'b0000, "R1 grant during reset");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R1 grant during reset");
    @(negedge clk);
    rst = 1'b0;
    idle(2, "R1 request in reset discarded");
  endtask

  task automatic t_single();
    step(1'b0, 1'b1, 2'd2, 1'b0, 4'b0000, "R3 no grant on capture cycle");
    step(1'b0, 1'b0, 2'd0, 1'b0, 4'b0100, "R3 grant one cycle after capture");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R2 single pulse");
    idle(2, "R5 single tenure over");
  endtask

  task automatic t_pair();
    step(1'b0, 1'b1, 2'd1, 1'b0, 4'b0000, "R3 capture m1");
    step(1'b0, 1'b1, 2'd3, 1'b1, 4'b0010, "R3 grant m1");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b1000, "R6 handover on last ack");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R10 burst beat 1");
    step(1'b0, 1'b0, 2'd0, 1'b0, 4'b0000, "R5 wait state");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R10 burst beat 2");
    step(1'b1, 1'b1, 2'd2, 1'b0, 4'b0000, "R5 burst beat 3");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0100, "R5 grant on 4th ack");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R5 single beat ends");
    idle(2, "R5 pair idle");
  endtask

  task automatic t_same();
    step(1'b0, 1'b1, 2'd0, 1'b0, 4'b0000, "R7 capture m0");
    step(1'b0, 1'b1, 2'd0, 1'b0, 4'b0001, "R7 first grant m0");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R7 none on last ack");
    step(1'b0, 1'b0, 2'd0, 1'b0, 4'b0000, "R7 none in turnaround");
    step(1'b0, 1'b0, 2'd0, 1'b0, 4'b0001, "R7 grant at t+2");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R7 second tenure ends");
    idle(2, "R7 idle");
  endtask

  task automatic t_idle_ta();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R8 idle ack");
    step(1'b1, 1'b1, 2'd1, 1'b1, 4'b0000, "R8 capture m1 burst");
    step(1'b0, 1'b1, 2'd2, 1'b0, 4'b0010, "R8 grant m1");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R8 full count kept");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0100, "R8 grant on 4th ack");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R8 m2 ends");
    idle(2, "R8 idle");
  endtask

  task automatic t_full();
    logic [1:0] order [6];
    order = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2};
    step(1'b0, 1'b1, 2'd0, 1'b1, 4'b0000, "R9 capture m0 burst");
    step(1'b0, 1'b1, order[0], 1'b0, 4'b0001, "R9 grant m0");
    for (int i = 1; i < 6; i++) step(1'b0, 1'b1, order[i], 1'b0, 4'b0000, "R10 filling");
    step(1'b0, 1'b1, 2'd3, 1'b0, 4'b0000, "R9 seventh request");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R10 m0 beats");
    for (int i = 0; i < 6; i++)
      step(1'b1, 1'b0, 2'd0, 1'b0, 4'(1 << order[i]), "R4 grant order");
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R9 dropped request not granted");
    idle(3, "R9 queue empty");
  endtask

  task automatic t_reset_mid();
    step(1'b0, 1'b1, 2'd1, 1'b1, 4'b0000, "R1 capture m1");
    step(1'b0, 1'b1, 2'd2, 1'b0, 4'b0010, "R1 grant m1");
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R1 reset mid tenure");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 2'd0, 1'b0, 4'b0000, "R1 queue cleared");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_pair();
    t_same();
    t_idle_ta();
    t_full();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule